// File: doc/BRIEF.md
# SPI Flash User-Transfer Engine

This block is a SPI master that performs custom full-duplex transfers of up to 64 bytes. It is built for talking to serial NOR flash parts. Software sees a small 32-bit register window. It fills a shared 64-byte data buffer with outgoing bytes and programs the transfer length as a bit count minus one. It then chooses whether chip-select should remain asserted afterwards, which allows a command and its payload to be split over several transfers. Finally it writes a start bit.

The engine shifts the buffer out most-significant bit first on MOSI in SPI mode 0. When input capture is enabled, it samples MISO on every rising SCLK edge and writes each received bit back into the buffer position whose bit has just been sent. Once the last bit is done, the engine raises a completion flag that software polls and clears. A software-reset bit aborts any activity and returns the configuration to its defaults.

Top module: `spi_user_xfer`

## Requirements
- R1: The buffer is addressed as 32-bit words at byte offsets 0x40 to 0x7C. It reads back what was written. Buffer byte n sits in word n/4, in bit lane 8*(n%4) (little-endian inside each word).
- R2: A write to offset 0x00 with bit 18 set starts a transfer. Offset 0x00 bit 18 reads 1 while the transfer runs and returns to 0 by itself when it completes.
- R3: A transfer produces exactly L+1 rising SCLK edges, where L is bits [25:17] of the length register at offset 0x20.
- R4: Bits leave MSB-first, starting with buffer byte 0 and moving to higher bytes in order. SCLK idles low. MOSI changes only while SCLK is low. MOSI is 0 when idle.
- R5: When bit 0 of the stage register (offset 0x1C) is 1, each bit sampled on MISO replaces the buffer bit that was sent in the same clock period. When that bit is 0, the buffer is left unchanged.
- R6: The completion flag, bit 4 at offset 0x30, goes to 1 when a transfer ends. Writing 0 to it clears it. Writing 1 to it has no effect.
- R7: cs_n is low for the whole transfer. At the end it goes high unless bit 30 at offset 0x2C is 1. In that case it stays low until a later transfer ends with that bit clear.
- R8: While a transfer runs, writes to the buffer and to offsets 0x1C, 0x20 and 0x2C are ignored.
- R9: A start request is ignored when the data-out stage bit (bit 27 at offset 0x1C) is 0, or when the mode bit (bit 30 at offset 0x30) is 1, meaning not master.
- R10: Writing 1 to bit 31 at offset 0x30 aborts any transfer. It releases cs_n, clears the start and completion flags, and zeroes every configuration field. The buffer contents are kept, and bit 31 always reads 0.
- R11: When the bit count is not a multiple of 8, only the top bits of the final byte are sent and replaced. Its lower bits keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI master data out |
| miso | input | 1 | SPI master data in |
| cs_n | output | 1 | SPI chip-select, active low |

## Verification
The main function is exercised with several transfer shapes:
- A short 4-byte duplex transfer, where the data sent and the data received differ byte by byte. This separates byte ordering from bit ordering.
- A 12-bit transfer, which shows whether the shifter stops mid-byte and leaves the untouched low bits of the last byte alone.
- A full 512-bit transfer, which reaches the last word of the buffer and the top of the length field.
- A capture-disabled run, which separates the transmit path from the in-place write-back.
- A held-then-released chip-select pair.

Start requests that should be rejected, writes during a busy transfer, and a reset in the middle of a transfer each check that the buffer, the flags and the SPI pins are left untouched, or are restored to their defaults.

// File: rtl/spi_user_xfer.sv
module spi_user_xfer #(
  parameter int BUF_BYTES = 64,
  parameter int HALF_CYC  = 2,
  parameter int ADDR_W    = $clog2(64 + BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int WORDS  = BUF_BYTES / 4;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int BIT_W  = $clog2(BUF_BYTES * 8);
  localparam int CNT_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STG  = ADDR_W'(8'h1c);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CSH  = ADDR_W'(8'h2c);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_BUF  = ADDR_W'(8'h40);

  logic [31:0]      mem [WORDS];
  logic             busy, done, slave_mode, cap_en, hold_cs, cs_act, sclk_q, rx_bit;
  logic [4:0]       stage;
  logic [BIT_W-1:0] len_m1, bi;
  logic [CNT_W-1:0] cnt;

  wire [ADDR_W-1:0] off      = reg_addr - A_BUF;
  wire [WIDX_W-1:0] widx     = off[2 +: WIDX_W];
  wire              in_buf   = reg_addr >= A_BUF;
  wire [WIDX_W-1:0] bw       = bi[BIT_W-1:5];
  wire [4:0]        bpos     = {bi[4:3], ~bi[2:0]};
  wire              half_end = cnt == CNT_W'(HALF_CYC - 1);
  wire              last     = bi == len_m1;
  wire              fall     = busy && sclk_q && half_end;
  wire              soft_rst = reg_wr && reg_addr == A_CTL && reg_wdata[31];
  wire              go       = reg_wr && reg_addr == A_CMD && reg_wdata[18] &&
                               !busy && stage[0] && !slave_mode;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata, off};

  assign sclk = sclk_q;
  assign cs_n = !cs_act;
  assign mosi = busy ? mem[bw][bpos] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; slave_mode <= 1'b0; cap_en <= 1'b0;
      hold_cs <= 1'b0; cs_act <= 1'b0; sclk_q <= 1'b0; rx_bit <= 1'b0;
      stage <= '0; len_m1 <= '0; bi <= '0; cnt <= '0;
    end else if (soft_rst) begin
      busy <= 1'b0; done <= 1'b0; slave_mode <= 1'b0; cap_en <= 1'b0;
      hold_cs <= 1'b0; cs_act <= 1'b0; sclk_q <= 1'b0; rx_bit <= 1'b0;
      stage <= '0; len_m1 <= '0; bi <= '0; cnt <= '0;
    end else begin
      if (reg_wr && !busy) begin
        case (reg_addr)
          A_STG: begin stage <= reg_wdata[31:27]; cap_en <= reg_wdata[0]; end
          A_LEN: len_m1 <= reg_wdata[17 +: BIT_W];
          A_CSH: hold_cs <= reg_wdata[30];
          A_CTL: slave_mode <= reg_wdata[30];
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == A_CTL && !reg_wdata[4]) done <= 1'b0;
      if (go) begin
        busy <= 1'b1; cs_act <= 1'b1; bi <= '0; cnt <= '0; sclk_q <= 1'b0;
      end else if (busy) begin
        if (!half_end) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_bit <= miso;
          end else begin
            sclk_q <= 1'b0;
            if (last) begin
              busy <= 1'b0; done <= 1'b1; cs_act <= hold_cs;
            end else begin
              bi <= bi + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (reg_wr && in_buf && !busy) mem[widx] <= reg_wdata;
    else if (fall && cap_en) mem[bw][bpos] <= rx_bit;
  end

  always_comb begin
    reg_rdata = '0;
    if (in_buf) reg_rdata = mem[widx];
    else case (reg_addr)
      A_CMD: reg_rdata[18] = busy;
      A_STG: begin reg_rdata[31:27] = stage; reg_rdata[0] = cap_en; end
      A_LEN: reg_rdata[17 +: BIT_W] = len_m1;
      A_CSH: reg_rdata[30] = hold_cs;
      A_CTL: begin reg_rdata[30] = slave_mode; reg_rdata[4] = done; end
      default: ;
    endcase
  end

  logic [BIT_W:0] edge_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_cnt <= '0;
    else if (go) edge_cnt <= '0;
    else if ($rose(sclk)) edge_cnt <= edge_cnt + 1'b1;
  end

  // R7
  cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !cs_n);
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk);
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy));
  // R3
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> edge_cnt == ({1'b0, len_m1} + 1'b1));

endmodule

// File: tb/sim_spi_user_xfer.sv
module sim_spi_user_xfer;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, miso, cs_n;

  int total = 0;
  int bad = 0;
  int sbi = 0;
  int rise_cnt = 0;
  logic [7:0] mcap [64];

  always #(CLK_PER/2) clk = ~clk;

  spi_user_xfer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  function automatic logic [7:0] txb(int k);
    return 8'(k * 7) ^ 8'hC3;
  endfunction
  function automatic logic [7:0] pat(int k);
    return 8'(k * 29 + 90);
  endfunction
  function automatic logic slv_bit(int i);
    logic [7:0] b;
    b = pat(i / 8);
    return b[7 - (i % 8)];
  endfunction

  assign miso = slv_bit(sbi);
  always @(negedge sclk) sbi = sbi + 1;
  always @(posedge sclk) begin
    if (rise_cnt < 512) mcap[rise_cnt / 8][7 - (rise_cnt % 8)] = mosi;
    rise_cnt = rise_cnt + 1;
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fill();
    for (int w = 0; w < 16; w++)
      wr(7'(64 + 4*w), {txb(4*w+3), txb(4*w+2), txb(4*w+1), txb(4*w)});
  endtask

  task automatic setup(int nbits, bit cap, bit hold);
    wr(7'h1c, {5'b00001, 26'd0, cap});
    wr(7'h20, 32'(nbits - 1) << 17);
    wr(7'h2c, {1'b0, hold, 30'd0});
    wr(7'h30, 32'd0);
    sbi = 0; rise_cnt = 0;
  endtask

  task automatic wait_done();
    logic [31:0] d;
    d = 0;
    while (!d[4]) rd(7'h30, d);
  endtask

  task automatic xfer(int nbits, bit cap, bit hold);
    setup(nbits, cap, hold);
    wr(7'h00, 32'h0004_0000);
    wait_done();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R7 reset cs_n", 32'(cs_n), 1);
    chk("R4 reset sclk", 32'(sclk), 0);
    chk("R4 reset mosi", 32'(mosi), 0);
    rd(7'h00, d); chk("R2 reset start", d, 0);
    rd(7'h30, d); chk("R6 reset done", d, 0);
  endtask

  task automatic t_buf();
    logic [31:0] d;
    fill();
    for (int w = 0; w < 16; w++) begin
      rd(7'(64 + 4*w), d);
      chk("R1 readback", d, {txb(4*w+3), txb(4*w+2), txb(4*w+1), txb(4*w)});
    end
  endtask

  task automatic t_duplex();
    logic [31:0] d;
    fill();
    setup(32, 1, 0);
    wr(7'h00, 32'h0004_0000);
    rd(7'h00, d); chk("R2 busy bit", d, 32'h0004_0000);
    chk("R7 cs during", 32'(cs_n), 0);
    wait_done();
    for (int k = 0; k < 4; k++) chk("R4 mosi byte order", 32'(mcap[k]), 32'(txb(k)));
    chk("R3 edges 32", rise_cnt, 32);
    rd(7'h40, d); chk("R5 rx in place", d, {pat(3), pat(2), pat(1), pat(0)});
    rd(7'h44, d); chk("R5 next word kept", d, {txb(7), txb(6), txb(5), txb(4)});
    rd(7'h00, d); chk("R2 self clear", d, 0);
    chk("R7 cs released", 32'(cs_n), 1);
  endtask

  task automatic t_nocap();
    logic [31:0] d;
    fill();
    xfer(24, 0, 0);
    for (int k = 0; k < 3; k++) chk("R4 mosi nocap", 32'(mcap[k]), 32'(txb(k)));
    rd(7'h40, d); chk("R5 no capture", d, {txb(3), txb(2), txb(1), txb(0)});
  endtask

  task automatic t_partial();
    logic [31:0] d;
    logic [7:0] b1;
    fill();
    xfer(12, 1, 0);
    chk("R3 edges 12", rise_cnt, 12);
    b1 = {pat(1)[7:4], txb(1)[3:0]};
    rd(7'h40, d); chk("R11 partial byte", d, {txb(3), txb(2), b1, pat(0)});
  endtask

  task automatic t_full();
    logic [31:0] d;
    fill();
    xfer(512, 1, 0);
    chk("R3 edges 512", rise_cnt, 512);
    chk("R4 last byte out", 32'(mcap[63]), 32'(txb(63)));
    rd(7'h7c, d); chk("R5 last word rx", d, {pat(63), pat(62), pat(61), pat(60)});
  endtask

  task automatic t_hold();
    fill();
    xfer(16, 0, 1);
    repeat (5) @(negedge clk);
    chk("R7 cs held", 32'(cs_n), 0);
    xfer(8, 0, 0);
    chk("R7 cs released after", 32'(cs_n), 1);
  endtask

  task automatic t_busywr();
    logic [31:0] d;
    fill();
    setup(32, 1, 0);
    wr(7'h00, 32'h0004_0000);
    wr(7'h40, 32'hDEAD_BEEF);
    wr(7'h20, 32'h0001_0000 << 1);
    wr(7'h2c, 32'h4000_0000);
    wait_done();
    rd(7'h40, d); chk("R8 buffer write ignored", d, {pat(3), pat(2), pat(1), pat(0)});
    rd(7'h20, d); chk("R8 length write ignored", d, 32'd31 << 17);
    rd(7'h2c, d); chk("R8 hold write ignored", d, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    setup(8, 0, 0);
    wr(7'h1c, 32'd0);
    wr(7'h00, 32'h0004_0000);
    repeat (20) @(negedge clk);
    rd(7'h00, d); chk("R9 no stage start", d, 0);
    chk("R9 no stage edges", rise_cnt, 0);
    chk("R9 no stage cs", 32'(cs_n), 1);
    wr(7'h1c, 32'h0800_0000);
    wr(7'h30, 32'h4000_0000);
    wr(7'h00, 32'h0004_0000);
    repeat (20) @(negedge clk);
    rd(7'h30, d); chk("R9 slave mode no done", d, 32'h4000_0000);
    chk("R9 slave mode edges", rise_cnt, 0);
    wr(7'h30, 32'd0);
  endtask

  task automatic t_done();
    logic [31:0] d;
    xfer(8, 0, 0);
    wr(7'h30, 32'h0000_0010);
    rd(7'h30, d); chk("R6 write 1 no effect", d, 32'h10);
    wr(7'h30, 32'd0);
    rd(7'h30, d); chk("R6 write 0 clears", d, 0);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    fill();
    setup(64, 1, 1);
    wr(7'h00, 32'h0004_0000);
    repeat (10) @(negedge clk);
    wr(7'h30, 32'h8000_0000);
    chk("R10 cs released", 32'(cs_n), 1);
    chk("R10 sclk idle", 32'(sclk), 0);
    rd(7'h00, d); chk("R10 start cleared", d, 0);
    rd(7'h30, d); chk("R10 ctl cleared", d, 0);
    rd(7'h1c, d); chk("R10 stage cleared", d, 0);
    rd(7'h20, d); chk("R10 length cleared", d, 0);
    rd(7'h2c, d); chk("R10 hold cleared", d, 0);
    rd(7'h48, d); chk("R10 buffer kept", d, {txb(11), txb(10), txb(9), txb(8)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_buf();
    t_duplex();
    t_nocap();
    t_partial();
    t_full();
    t_hold();
    t_busywr();
    t_ignore();
    t_done();
    t_srst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule